// File: doc/BRIEF.md
# Boot Overlay Address Decoder

This block sits between an 8-bit CPU and its memories and turns a 16-bit address bus into chip selects. It also steers read data back to the CPU. Immediately after reset, a 256-byte start-up ROM covers the bottom of the address space. While that overlay is active, the start-up program runs from the ROM instead of from the cartridge. The program ends by storing the value 0x01 to a control address. From then on the overlay is gone, and the cartridge answers at those addresses until the next reset.

Besides the overlay, the decoder routes the rest of the address space in four ways. It sends the cartridge program and external RAM windows to the cartridge select. It sends the 8 KB internal work RAM to a work RAM select, and it folds the echo window above that RAM back onto the same RAM. Every remaining address, which covers video memory, sprite memory and I/O, goes to one shared "other" select.

The strobes are plain single-cycle controls and have no valid/ready handshake. The bus never stalls, and every access completes in the cycle it is presented. Each memory behind the decoder is synchronous, so `cpu_rdata` presents the selected byte one clock after the read strobe.

Top module: `bootmap_decoder`

## Requirements
- R1: After reset the overlay is active, `cpu_rdata` reads 0xFF, and with no strobe asserted every select and write enable is low.
- R2: While the overlay is active, a read of 0x0000..0x00FF asserts only `boot_cs`, with `boot_addr` equal to address bits 7..0. At any time at most one of `boot_cs`, `cart_cs`, `wram_cs`, `other_cs` is high.
- R3: A write of data 0x01 to address 0xFF50 removes the overlay from the following cycle on. After that, reads and writes of 0x0000..0x00FF go to the cartridge (`cart_cs`, and `cart_we` on writes).
- R4: The overlay-off state is sticky and only reset restores the overlay. A write of any other value to 0xFF50, or of 0x01 to any other address, leaves the overlay state unchanged.
- R5: While the overlay is active, a write to 0x0000..0x00FF asserts no select and no write enable.
- R6: Addresses 0x0100..0x7FFF and 0xA000..0xBFFF always select the cartridge, and 0x0100 is cartridge in both overlay states.
- R7: Addresses 0xC000..0xFDFF select work RAM, with `wram_addr` equal to address bits 12..0. The window 0xE000..0xFDFF therefore reaches the same bytes as 0xC000..0xDDFF. A write also raises `wram_we`.
- R8: Addresses 0x8000..0x9FFF and 0xFE00..0xFFFF, including 0xFF50, assert `other_cs`, and raise `other_we` on writes.
- R9: A select is asserted only in a cycle with `cpu_rd` or `cpu_wr` high. A write enable is asserted only together with its select and `cpu_wr`.
- R10: In the clock after a read, `cpu_rdata` equals the read-data input of the region that the read selected. In the clock after a cycle without a read it is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, one clock after the read |
| boot_cs | output | 1 | Start-up ROM read select |
| boot_addr | output | 8 | Start-up ROM byte index |
| boot_rdata | input | 8 | Start-up ROM data |
| cart_cs | output | 1 | Cartridge select |
| cart_we | output | 1 | Cartridge write enable |
| cart_rdata | input | 8 | Cartridge data |
| wram_cs | output | 1 | Work RAM select |
| wram_we | output | 1 | Work RAM write enable |
| wram_addr | output | 13 | Work RAM index |
| wram_rdata | input | 8 | Work RAM data |
| other_cs | output | 1 | Select for all remaining addresses |
| other_we | output | 1 | Write enable for remaining addresses |
| other_rdata | input | 8 | Data from remaining addresses |

## Verification
The hidden state is the overlay flag and the registered read source. A wrongly set or cleared overlay flag shows up on the first access to 0x0000..0x00FF: a select appears on the wrong device in that same cycle, and the data from the wrong device follows one clock later. A stale read-source register shows a wrong byte on `cpu_rdata` in the very next clock. The sequence therefore probes the low page right after each control write and after a second reset.

// File: rtl/bootmap_pkg.sv
package bootmap_pkg;
  typedef enum logic [1:0] {
    RG_BOOT  = 2'd0,
    RG_CART  = 2'd1,
    RG_WRAM  = 2'd2,
    RG_OTHER = 2'd3
  } region_e;
endpackage

// File: rtl/bootmap_unmap_latch.sv
module bootmap_unmap_latch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFF50,
  parameter logic [DATA_W-1:0] CTRL_VAL  = 8'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              unmapped
);
  logic hit;
  assign hit = wr && (addr == CTRL_ADDR) && (wdata == CTRL_VAL);

  always_ff @(posedge clk) begin
    if (!rst_n)   unmapped <= 1'b0;
    else if (hit) unmapped <= 1'b1;
  end

  // R3: the qualifying write takes effect next cycle
  a_r3_unmap_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == CTRL_ADDR && wdata == CTRL_VAL) |=> unmapped);
  // R4: once off, stays off
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |=> unmapped);
  // R4: non-qualifying cycles do not remove the overlay
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!unmapped && !(wr && addr == CTRL_ADDR && wdata == CTRL_VAL)) |=> !unmapped);
endmodule

// File: rtl/bootmap_region_decode.sv
module bootmap_region_decode
  import bootmap_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BOOT_AW = 8,
  parameter logic [ADDR_W-1:0] VRAM_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] XRAM_BASE = 16'hA000,
  parameter logic [ADDR_W-1:0] WRAM_BASE = 16'hC000,
  parameter logic [ADDR_W-1:0] ECHO_END  = 16'hFE00
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              overlay_on,
  output region_e           region
);
  localparam logic [ADDR_W-1:0] BOOT_END = ADDR_W'(1) << BOOT_AW;

  always_comb begin
    if (overlay_on && addr < BOOT_END) region = RG_BOOT;
    else if (addr < VRAM_BASE)         region = RG_CART;
    else if (addr < XRAM_BASE)         region = RG_OTHER;
    else if (addr < WRAM_BASE)         region = RG_CART;
    else if (addr < ECHO_END)          region = RG_WRAM;
    else                               region = RG_OTHER;
  end
endmodule

// File: rtl/bootmap_rdata_mux.sv
module bootmap_rdata_mux
  import bootmap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] IDLE_VAL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  region_e           region,
  input  logic [DATA_W-1:0] boot_rdata,
  input  logic [DATA_W-1:0] cart_rdata,
  input  logic [DATA_W-1:0] wram_rdata,
  input  logic [DATA_W-1:0] other_rdata,
  output logic [DATA_W-1:0] rdata
);
  logic    rd_q;
  region_e src_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      src_q <= RG_OTHER;
    end else begin
      rd_q  <= rd;
      src_q <= region;
    end
  end

  always_comb begin
    if (!rd_q) rdata = IDLE_VAL;
    else begin
      unique case (src_q)
        RG_BOOT: rdata = boot_rdata;
        RG_CART: rdata = cart_rdata;
        RG_WRAM: rdata = wram_rdata;
        default: rdata = other_rdata;
      endcase
    end
  end

  // R10: data returns from the region read one clock earlier
  a_r10_wram_return: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && region == RG_WRAM) |=> (rdata == wram_rdata));
  a_r10_boot_return: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && region == RG_BOOT) |=> (rdata == boot_rdata));
  a_r10_idle_value: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (rdata == IDLE_VAL));
endmodule

// File: rtl/bootmap_decoder.sv
module bootmap_decoder
  import bootmap_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int BOOT_AW = 8,
  parameter int WRAM_AW = 13,
  parameter logic [ADDR_W-1:0] VRAM_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] XRAM_BASE = 16'hA000,
  parameter logic [ADDR_W-1:0] WRAM_BASE = 16'hC000,
  parameter logic [ADDR_W-1:0] ECHO_END  = 16'hFE00,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFF50,
  parameter logic [DATA_W-1:0] CTRL_VAL  = 8'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic               boot_cs,
  output logic [BOOT_AW-1:0] boot_addr,
  input  logic [DATA_W-1:0]  boot_rdata,
  output logic               cart_cs,
  output logic               cart_we,
  input  logic [DATA_W-1:0]  cart_rdata,
  output logic               wram_cs,
  output logic               wram_we,
  output logic [WRAM_AW-1:0] wram_addr,
  input  logic [DATA_W-1:0]  wram_rdata,
  output logic               other_cs,
  output logic               other_we,
  input  logic [DATA_W-1:0]  other_rdata
);
  logic    unmapped;
  logic    access;
  region_e region;

  assign access = cpu_rd || cpu_wr;

  bootmap_unmap_latch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_ADDR(CTRL_ADDR), .CTRL_VAL(CTRL_VAL)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .wr(cpu_wr), .addr(cpu_addr),
    .wdata(cpu_wdata), .unmapped(unmapped)
  );

  bootmap_region_decode #(
    .ADDR_W(ADDR_W), .BOOT_AW(BOOT_AW), .VRAM_BASE(VRAM_BASE),
    .XRAM_BASE(XRAM_BASE), .WRAM_BASE(WRAM_BASE), .ECHO_END(ECHO_END)
  ) u_decode (
    .addr(cpu_addr), .overlay_on(!unmapped), .region(region)
  );

  // The start-up ROM is read-only: writes there are dropped entirely.
  assign boot_cs   = cpu_rd && (region == RG_BOOT);
  assign cart_cs   = access && (region == RG_CART);
  assign wram_cs   = access && (region == RG_WRAM);
  assign other_cs  = access && (region == RG_OTHER);
  assign cart_we   = cpu_wr && (region == RG_CART);
  assign wram_we   = cpu_wr && (region == RG_WRAM);
  assign other_we  = cpu_wr && (region == RG_OTHER);
  assign boot_addr = cpu_addr[BOOT_AW-1:0];
  assign wram_addr = cpu_addr[WRAM_AW-1:0];

  bootmap_rdata_mux #(.DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .rd(cpu_rd), .region(region),
    .boot_rdata(boot_rdata), .cart_rdata(cart_rdata),
    .wram_rdata(wram_rdata), .other_rdata(other_rdata),
    .rdata(cpu_rdata)
  );

  // R2: never more than one device selected
  a_r2_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({boot_cs, cart_cs, wram_cs, other_cs}));
  // R5: a write never reaches the ROM select
  a_r5_no_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !cpu_rd) |-> !boot_cs);
  // R6: program entry point is always cartridge
  a_r6_entry_cart: assert property (@(posedge clk) disable iff (!rst_n)
    (access && cpu_addr == 16'h0100) |-> cart_cs);
  // R7: work RAM only inside its window and echo
  a_r7_wram_window: assert property (@(posedge clk) disable iff (!rst_n)
    wram_cs |-> (cpu_addr >= WRAM_BASE && cpu_addr < ECHO_END));
  // R9: no select without a strobe, no write enable without a write
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !access |-> !(boot_cs || cart_cs || wram_cs || other_cs));
  a_r9_we_needs_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (cart_we || wram_we || other_we) |-> cpu_wr);
endmodule

// File: tb/bootmap_decoder_test.sv
module bootmap_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0, cpu_rdata;
  logic        boot_cs, cart_cs, cart_we, wram_cs, wram_we, other_cs, other_we;
  logic [7:0]  boot_addr;
  logic [12:0] wram_addr;
  logic [7:0]  boot_rdata = 8'h3C, cart_rdata = 8'hA5;
  logic [7:0]  wram_rdata = 8'h5A, other_rdata = 8'h77;

  int vectors = 0, fails = 0;
  bit model_off = 0, done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  bootmap_decoder uut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {other,wram,cart,boot}
  function automatic logic [3:0] model_region(input logic [15:0] a);
    if (!model_off && a < 16'h0100) return 4'b0001;
    if (a < 16'h8000) return 4'b0010;
    if (a < 16'hA000) return 4'b1000;
    if (a < 16'hC000) return 4'b0010;
    if (a < 16'hFE00) return 4'b0100;
    return 4'b1000;
  endfunction

  task automatic access(input logic [15:0] a, input logic r, input logic w,
                        input logic [7:0] d, input string req);
    logic [3:0] reg4, sel, we;
    logic [7:0] exp_rd;
    @(negedge clk);
    cpu_addr = a; cpu_rd = r; cpu_wr = w; cpu_wdata = d;
    #1;
    reg4 = model_region(a);
    sel  = (r || w) ? reg4 : 4'b0000;
    if (!r) sel[0] = 1'b0;
    we   = w ? {reg4[3:1], 1'b0} : 4'b0000;
    check({other_cs, wram_cs, cart_cs, boot_cs} == sel, req,
          {other_cs, wram_cs, cart_cs, boot_cs}, sel);
    check({other_we, wram_we, cart_we} == we[3:1], req,
          {other_we, wram_we, cart_we}, we[3:1]);
    if (sel[2]) check(wram_addr == a[12:0], req, wram_addr, a[12:0]);
    if (sel[0]) check(boot_addr == a[7:0], req, boot_addr, a[7:0]);
    exp_rd = !r ? 8'hFF : reg4[0] ? boot_rdata : reg4[1] ? cart_rdata :
             reg4[2] ? wram_rdata : other_rdata;
    exp_q.push_back(exp_rd);
    tag_q.push_back({req, " R10 rdata"});
    if (w && a == 16'hFF50 && d == 8'h01) model_off = 1;
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(cpu_rdata === e, t, cpu_rdata, e);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cpu_rd = 0; cpu_wr = 0;
    model_off = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    check(cpu_rdata == 8'hFF, "R1 rdata", cpu_rdata, 8'hFF);
    check({boot_cs, cart_cs, wram_cs, other_cs, cart_we, wram_we, other_we} == 0,
          "R1 selects", {boot_cs, cart_cs, wram_cs, other_cs}, 0);
  endtask

  initial begin
    do_reset();
    access(16'h0000, 1, 0, 0, "R2 rom low");
    access(16'h00FF, 1, 0, 0, "R2 rom top");
    access(16'h0100, 1, 0, 0, "R6 entry");
    access(16'h0010, 0, 1, 8'h99, "R5 rom write");
    access(16'hFF50, 0, 1, 8'h02, "R4 wrong value");
    access(16'hFF51, 0, 1, 8'h01, "R4 wrong addr");
    access(16'h0000, 1, 0, 0, "R4 still rom");
    access(16'hFF50, 0, 1, 8'h01, "R3 unmap write");
    access(16'h0000, 1, 0, 0, "R3 cart low");
    access(16'h00FF, 1, 0, 0, "R3 cart top");
    access(16'h0020, 0, 1, 8'h11, "R3 cart write");
    access(16'hFF50, 0, 1, 8'h00, "R4 rewrite");
    access(16'h0005, 1, 0, 0, "R4 sticky");
    access(16'h0100, 1, 0, 0, "R6 entry after");
    access(16'h7FFF, 1, 0, 0, "R6 rom end");
    access(16'h8000, 1, 0, 0, "R8 video low");
    access(16'h9FFF, 0, 1, 8'h12, "R8 video write");
    access(16'hA000, 1, 0, 0, "R6 ext ram");
    access(16'hBFFF, 1, 0, 0, "R6 ext ram top");
    access(16'hC000, 1, 0, 0, "R7 wram base");
    access(16'hDFFF, 1, 0, 0, "R7 wram top");
    access(16'hE000, 1, 0, 0, "R7 echo base");
    access(16'hE123, 1, 0, 0, "R7 echo mid");
    access(16'hFDFF, 1, 0, 0, "R7 echo top");
    access(16'hC345, 0, 1, 8'h44, "R7 wram write");
    access(16'hFE00, 1, 0, 0, "R8 above echo");
    access(16'hFFFF, 1, 0, 0, "R8 top");
    access(16'h4000, 0, 0, 0, "R9 idle");
    access(16'hC000, 0, 0, 0, "R9 idle wram");
    do_reset();
    access(16'h0000, 1, 0, 0, "R4 reset restores");
    access(16'h0042, 0, 1, 8'h01, "R5 rom write again");
    access(16'h0000, 0, 0, 0, "R10 idle tail");
    repeat (3) @(posedge clk);
    #2;
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      vectors++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule